// File: doc/BRIEF.md
# Posted Write Buffer with Read Forwarding

This block sits between a write-through cache and main memory. Processor writes are accepted into a small circular queue without waiting for memory. The queue then drains in the background, one word per memory handshake, and the oldest entry goes first. While writes are still queued, every processor read first searches the queue. If the address is found, the newest queued value is returned at once and memory is not touched.

A second storage element can take one evicted dirty block from a write-back cache. Once the block is captured, a read miss that is waiting may use memory first. The held block's words are written back afterwards, one word per handshake. Reads that fall inside the held block are answered from the held copy.

The memory port carries one transaction at a time. A request holds its address, direction and data until the memory acknowledges it, and read data arrives with the acknowledge.

Top module: `posted_wbuf`

## Requirements
- R1: After reset, `wr_ready`, `rd_ready` and `ev_ready` are 1, and `mem_req` and `rd_resp_valid` are 0.
- R2: A write is taken in every cycle where `wr_valid` and `wr_ready` are both high, whatever the memory is doing. The queue can absorb DEPTH writes while memory never acknowledges.
- R3: With DEPTH writes queued, `wr_ready` is 0. A write presented then is not stored and never reaches memory. `wr_ready` returns to 1 once one entry drains.
- R4: Queued writes reach memory as writes (`mem_we`=1), one per acknowledge, in the order they were accepted. Each entry is written exactly once.
- R5: A read accepted while its word address matches a queued write raises `rd_resp_valid` in the following cycle with the queued data. No memory read is issued for it.
- R6: When several queued entries match a read address, the data comes from the most recently accepted entry.
- R7: A read that matches nothing becomes a memory read (`mem_we`=0) at that address. `rd_resp_valid` rises in the cycle after the acknowledge, carrying `mem_rdata`, and `rd_ready` stays 0 until then.
- R8: While a read miss is waiting, the next memory transaction started is that read. It goes ahead of queued writes and held-block words, but an already started transaction finishes first.
- R9: `ev_ready` is 1 only when no block is held and the queue is empty. A read inside the held block (word address = block number concatenated with the word offset) is answered in the next cycle from the held copy.
- R10: Held-block words are written to memory in ascending offset order. The write-back happens after any read miss already waiting, and before any write queued after the block was taken.
- R11: Once raised, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged until the cycle with `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Processor write request |
| wr_ready | output | 1 | Queue can take a write |
| wr_addr | input | AW | Write word address |
| wr_data | input | DW | Write data |
| rd_valid | input | 1 | Processor read request |
| rd_ready | output | 1 | Read port can take a read |
| rd_addr | input | AW | Read word address |
| rd_resp_valid | output | 1 | Read data valid (one cycle) |
| rd_resp_data | output | DW | Read data |
| ev_valid | input | 1 | Evicted block offered |
| ev_ready | output | 1 | Evicted block can be taken |
| ev_blk | input | AW-log2(BLK_WORDS) | Block number of the evicted block |
| ev_data | input | BLK_WORDS*DW | Block words, word k at bits k*DW upward |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory completes the transaction |
| mem_rdata | input | DW | Memory read data, valid with `mem_ack` |

## Verification
A wrong queue pointer or count shows up as a stale or missing forwarded value on the very next read response. It also shows up later as a skipped, repeated or reordered write in the memory write sequence, or as `wr_ready` dropping early or late while memory is stalled. A wrong arbitration choice or held-block index shows up within one memory handshake as a transaction of the wrong kind or at the wrong address. The tests therefore stall memory deliberately to fill the buffer, then record every handshake in order and compare the final memory contents.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
   typedef enum logic [1:0] {
      TXN_READ = 2'd0,
      TXN_HOLD = 2'd1,
      TXN_QUEUE = 2'd2
   } pwb_txn_e;

   typedef enum logic {
      RS_IDLE = 1'b0,
      RS_WAIT = 1'b1
   } pwb_rd_e;
endpackage

// File: rtl/pwb_queue.sv
module pwb_queue #(
   parameter int AW = 16,
   parameter int DW = 32,
   parameter int DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [AW-1:0] push_addr,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic          full,
   output logic          empty,
   output logic [AW-1:0] head_addr,
   output logic [DW-1:0] head_data,
   input  logic [AW-1:0] q_addr,
   output logic          q_hit,
   output logic [DW-1:0] q_data
);
   localparam int PW = $clog2(DEPTH);

   logic [AW-1:0] addr_q [DEPTH];
   logic [DW-1:0] data_q [DEPTH];
   logic [PW-1:0] wp, rp;
   logic [PW:0]   cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= wp + 1'b1;
         if (pop)  rp <= rp + 1'b1;
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push) begin
         addr_q[wp] <= push_addr;
         data_q[wp] <= push_data;
      end
   end

   assign full      = (cnt == (PW+1)'(DEPTH));
   assign empty     = (cnt == '0);
   assign head_addr = addr_q[rp];
   assign head_data = data_q[rp];

   // Walk from oldest to newest; a later match overrides, so the youngest wins.
   always_comb begin
      logic [PW-1:0] idx;
      idx    = '0;
      q_hit  = 1'b0;
      q_data = '0;
      for (int k = 0; k < DEPTH; k++) begin
         idx = rp + PW'(k);
         if (((PW+1)'(k) < cnt) && (addr_q[idx] == q_addr)) begin
            q_hit  = 1'b1;
            q_data = data_q[idx];
         end
      end
   end
endmodule

// File: rtl/pwb_hold.sv
module pwb_hold #(
   parameter int AW = 16,
   parameter int DW = 32,
   parameter int WORDS = 4,
   parameter bit ENABLE = 1'b1,
   localparam int OW = $clog2(WORDS),
   localparam int BW = AW - OW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [BW-1:0]    load_blk,
   input  logic [WORDS*DW-1:0] load_data,
   input  logic             word_done,
   output logic             can_load,
   output logic             busy,
   output logic [AW-1:0]    cur_addr,
   output logic [DW-1:0]    cur_data,
   input  logic [AW-1:0]    q_addr,
   output logic             q_hit,
   output logic [DW-1:0]    q_data
);
   generate
      if (ENABLE) begin : g_hold
         logic          vld;
         logic [BW-1:0] blk;
         logic [OW-1:0] wi;
         logic [DW-1:0] words [WORDS];

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld <= 1'b0;
               wi  <= '0;
            end else if (load) begin
               vld <= 1'b1;
               wi  <= '0;
            end else if (word_done) begin
               wi <= wi + 1'b1;
               if (wi == OW'(WORDS-1)) vld <= 1'b0;
            end
         end

         always_ff @(posedge clk) begin
            if (load) begin
               blk <= load_blk;
               for (int k = 0; k < WORDS; k++) words[k] <= load_data[k*DW +: DW];
            end
         end

         assign can_load = !vld;
         assign busy     = vld;
         assign cur_addr = {blk, wi};
         assign cur_data = words[wi];
         assign q_hit    = vld && (q_addr[AW-1:OW] == blk);
         assign q_data   = words[q_addr[OW-1:0]];
      end else begin : g_none
         assign can_load = 1'b0;
         assign busy     = 1'b0;
         assign cur_addr = '0;
         assign cur_data = '0;
         assign q_hit    = 1'b0;
         assign q_data   = '0;
      end
   endgenerate
endmodule

// File: rtl/posted_wbuf.sv
module posted_wbuf #(
   parameter int AW = 16,
   parameter int DW = 32,
   parameter int DEPTH = 4,
   parameter int BLK_WORDS = 4,
   parameter bit HOLD_EN = 1'b1,
   localparam int OW = $clog2(BLK_WORDS),
   localparam int BW = AW - OW
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_valid,
   output logic                  wr_ready,
   input  logic [AW-1:0]         wr_addr,
   input  logic [DW-1:0]         wr_data,
   input  logic                  rd_valid,
   output logic                  rd_ready,
   input  logic [AW-1:0]         rd_addr,
   output logic                  rd_resp_valid,
   output logic [DW-1:0]         rd_resp_data,
   input  logic                  ev_valid,
   output logic                  ev_ready,
   input  logic [BW-1:0]         ev_blk,
   input  logic [BLK_WORDS*DW-1:0] ev_data,
   output logic                  mem_req,
   output logic                  mem_we,
   output logic [AW-1:0]         mem_addr,
   output logic [DW-1:0]         mem_wdata,
   input  logic                  mem_ack,
   input  logic [DW-1:0]         mem_rdata
);
   import pwb_pkg::*;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("posted_wbuf: DEPTH must be a power of two, at least 2");
      end
      if (BLK_WORDS < 2 || (BLK_WORDS & (BLK_WORDS - 1)) != 0) begin : g_bad_blk
         $error("posted_wbuf: BLK_WORDS must be a power of two, at least 2");
      end
      if (AW <= OW || DW < 1) begin : g_bad_width
         $error("posted_wbuf: AW must exceed the block offset width");
      end
   endgenerate

   logic          q_full, q_empty, q_hit, h_hit, h_busy, h_can_load;
   logic [AW-1:0] q_head_addr, h_cur_addr;
   logic [DW-1:0] q_head_data, q_fwd, h_cur_data, h_fwd;
   logic          fifo_push, fifo_pop, ev_load, hold_step;

   logic          txn_act;
   pwb_txn_e      txn_kind;
   pwb_rd_e       rd_st;
   logic [AW-1:0] rd_addr_q;
   logic          rd_take, rd_hit;

   assign wr_ready  = !q_full;
   assign fifo_push = wr_valid && wr_ready;
   assign ev_ready  = h_can_load && q_empty;
   assign ev_load   = ev_valid && ev_ready;
   assign fifo_pop  = txn_act && mem_ack && (txn_kind == TXN_QUEUE);
   assign hold_step = txn_act && mem_ack && (txn_kind == TXN_HOLD);

   pwb_queue #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) queue_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (fifo_push),
      .push_addr (wr_addr),
      .push_data (wr_data),
      .pop       (fifo_pop),
      .full      (q_full),
      .empty     (q_empty),
      .head_addr (q_head_addr),
      .head_data (q_head_data),
      .q_addr    (rd_addr),
      .q_hit     (q_hit),
      .q_data    (q_fwd)
   );

   pwb_hold #(.AW(AW), .DW(DW), .WORDS(BLK_WORDS), .ENABLE(HOLD_EN)) hold_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (ev_load),
      .load_blk  (ev_blk),
      .load_data (ev_data),
      .word_done (hold_step),
      .can_load  (h_can_load),
      .busy      (h_busy),
      .cur_addr  (h_cur_addr),
      .cur_data  (h_cur_data),
      .q_addr    (rd_addr),
      .q_hit     (h_hit),
      .q_data    (h_fwd)
   );

   // Memory transaction: one at a time, read miss first, then held block, then queue.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         txn_act  <= 1'b0;
         txn_kind <= TXN_READ;
      end else if (txn_act) begin
         if (mem_ack) txn_act <= 1'b0;
      end else if (rd_st == RS_WAIT) begin
         txn_act  <= 1'b1;
         txn_kind <= TXN_READ;
      end else if (h_busy) begin
         txn_act  <= 1'b1;
         txn_kind <= TXN_HOLD;
      end else if (!q_empty) begin
         txn_act  <= 1'b1;
         txn_kind <= TXN_QUEUE;
      end
   end

   always_comb begin
      mem_req = txn_act;
      mem_we  = txn_act && (txn_kind != TXN_READ);
      case (txn_kind)
         TXN_HOLD: begin
            mem_addr  = h_cur_addr;
            mem_wdata = h_cur_data;
         end
         TXN_QUEUE: begin
            mem_addr  = q_head_addr;
            mem_wdata = q_head_data;
         end
         default: begin
            mem_addr  = rd_addr_q;
            mem_wdata = '0;
         end
      endcase
   end

   // Read port: forward from the buffer or wait for one memory read.
   assign rd_ready = (rd_st == RS_IDLE);
   assign rd_take  = rd_valid && rd_ready;
   assign rd_hit   = q_hit || h_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_st         <= RS_IDLE;
         rd_addr_q     <= '0;
         rd_resp_valid <= 1'b0;
         rd_resp_data  <= '0;
      end else begin
         rd_resp_valid <= 1'b0;
         if (rd_take) begin
            if (rd_hit) begin
               rd_resp_valid <= 1'b1;
               rd_resp_data  <= q_hit ? q_fwd : h_fwd;
            end else begin
               rd_st     <= RS_WAIT;
               rd_addr_q <= rd_addr;
            end
         end else if (rd_st == RS_WAIT && txn_act && txn_kind == TXN_READ && mem_ack) begin
            rd_st         <= RS_IDLE;
            rd_resp_valid <= 1'b1;
            rd_resp_data  <= mem_rdata;
         end
      end
   end
endmodule

// File: rtl/pwb_chk.sv
module pwb_chk #(
   parameter int AW = 16,
   parameter int DW = 32,
   parameter int DEPTH = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_valid,
   input logic          wr_ready,
   input logic          rd_valid,
   input logic          rd_ready,
   input logic          rd_resp_valid,
   input logic          ev_ready,
   input logic          mem_req,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic [DW-1:0] mem_wdata,
   input logic          mem_ack,
   input logic          fifo_pop
);
   localparam int OCW = $clog2(DEPTH) + 2;
   logic [OCW-1:0] occ;

   always_ff @(posedge clk) begin
      if (!rst_n) occ <= '0;
      else occ <= occ + OCW'(wr_valid && wr_ready) - OCW'(fifo_pop);
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)); // R11
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= OCW'(DEPTH)); // R3
   AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      occ == OCW'(DEPTH) |-> !wr_ready); // R3
   AST_RESP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_resp_valid |-> $past(rd_valid && rd_ready) || $past(mem_ack && !mem_we)); // R5
   AST_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_ready && !mem_req |=> mem_req && !mem_we); // R8
   AST_EVICT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      ev_ready |-> occ == '0); // R9
endmodule

bind posted_wbuf pwb_chk #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .wr_valid      (wr_valid),
   .wr_ready      (wr_ready),
   .rd_valid      (rd_valid),
   .rd_ready      (rd_ready),
   .rd_resp_valid (rd_resp_valid),
   .ev_ready      (ev_ready),
   .mem_req       (mem_req),
   .mem_we        (mem_we),
   .mem_addr      (mem_addr),
   .mem_wdata     (mem_wdata),
   .mem_ack       (mem_ack),
   .fifo_pop      (fifo_pop)
);

// File: tb/posted_wbuf_tb_top.sv
module posted_wbuf_tb_top;
   localparam int AW = 8;
   localparam int DW = 32;
   localparam int DEPTH = 4;
   localparam int BLK = 4;
   localparam int BW = AW - 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic wr_valid = 0, rd_valid = 0, ev_valid = 0;
   logic [AW-1:0] wr_addr = '0, rd_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [BW-1:0] ev_blk = '0;
   logic [BLK*DW-1:0] ev_data = '0;
   logic wr_ready, rd_ready, ev_ready, rd_resp_valid;
   logic [DW-1:0] rd_resp_data;
   logic mem_req, mem_we, mem_ack;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, mem_rdata;

   posted_wbuf #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .BLK_WORDS(BLK)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
      .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
      .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_blk(ev_blk), .ev_data(ev_data),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   // Memory model: fixed latency, can be stalled, logs every handshake.
   logic [DW-1:0] mem_arr [256];
   logic          ack_r;
   logic [DW-1:0] rdata_r;
   int            lat_cnt;
   int            log_n;
   logic          log_we [64];
   logic [AW-1:0] log_addr [64];
   logic          mem_stall = 1'b0;
   assign mem_ack   = ack_r;
   assign mem_rdata = rdata_r;

   always @(posedge clk) begin
      if (!rst_n) begin
         ack_r   <= 1'b0;
         lat_cnt <= 0;
         log_n   <= 0;
         rdata_r <= '0;
         for (int i = 0; i < 256; i++) mem_arr[i] <= 32'hA000_0000 | i;
      end else if (ack_r) begin
         ack_r <= 1'b0;
      end else if (mem_req && !mem_stall) begin
         if (lat_cnt == 2) begin
            ack_r   <= 1'b1;
            lat_cnt <= 0;
            if (mem_we) mem_arr[mem_addr] <= mem_wdata;
            else rdata_r <= mem_arr[mem_addr];
            if (log_n < 64) begin
               log_we[log_n]   <= mem_we;
               log_addr[log_n] <= mem_addr;
            end
            log_n <= log_n + 1;
         end else begin
            lat_cnt <= lat_cnt + 1;
         end
      end
   end

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic put_write(input logic [AW-1:0] a, input logic [DW-1:0] d, output int waits);
      @(negedge clk);
      wr_valid = 1; wr_addr = a; wr_data = d;
      #1;
      waits = 0;
      while (!wr_ready && waits < 2000) begin
         @(negedge clk); #1; waits++;
      end
      @(negedge clk);
      wr_valid = 0;
   endtask

   task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d, output int lat, output bit after_ack);
      bit prev;
      int w;
      @(negedge clk);
      rd_valid = 1; rd_addr = a;
      #1;
      w = 0;
      while (!rd_ready && w < 2000) begin
         @(negedge clk); #1; w++;
      end
      @(negedge clk);
      rd_valid = 0;
      #1;
      lat = 0; prev = 0;
      while (!rd_resp_valid && lat < 2000) begin
         prev = mem_ack && !mem_we;
         @(negedge clk); #1; lat++;
      end
      after_ack = prev;
      d = rd_resp_data;
   endtask

   task automatic put_evict(input logic [BW-1:0] b, input logic [DW-1:0] base);
      int w;
      @(negedge clk);
      ev_valid = 1; ev_blk = b;
      for (int k = 0; k < BLK; k++) ev_data[k*DW +: DW] = base + k;
      #1;
      w = 0;
      while (!ev_ready && w < 2000) begin
         @(negedge clk); #1; w++;
      end
      @(negedge clk);
      ev_valid = 0;
   endtask

   task automatic wait_idle();
      int quiet = 0;
      int t = 0;
      while (quiet < 4 && t < 5000) begin
         @(negedge clk); #1; t++;
         if (!mem_req) quiet++; else quiet = 0;
      end
   endtask

   task automatic t_reset();
      @(negedge clk); #1;
      check(wr_ready && rd_ready && ev_ready, "R1 ready flags",
            {29'd0, wr_ready, rd_ready, ev_ready}, 32'h7);
      check(!mem_req && !rd_resp_valid, "R1 idle outputs",
            {30'd0, mem_req, rd_resp_valid}, 32'h0);
   endtask

   task automatic t_fill_and_drain();
      int w, base, lat; bit aa; logic [DW-1:0] d;
      mem_stall = 1;
      base = log_n;
      for (int i = 0; i < DEPTH; i++) begin
         put_write(8'h20 + i, 32'h1100 + i, w);
         check(w == 0, "R2 write taken without wait", w, 0);
      end
      #1;
      check(!wr_ready, "R3 full stalls writer", wr_ready, 0);
      @(negedge clk);
      wr_valid = 1; wr_addr = 8'h30; wr_data = 32'hDEAD;
      for (int c = 0; c < 3; c++) begin
         #1; check(!wr_ready, "R3 stays stalled", wr_ready, 0);
         @(negedge clk);
      end
      wr_valid = 0;
      do_read(8'h21, d, lat, aa);
      check(d == 32'h1101, "R5 forwarded data", d, 32'h1101);
      check(lat == 0, "R5 next-cycle response", lat, 0);
      check(log_n == base, "R5 no memory access", log_n - base, 0);
      mem_stall = 0;
      wait_idle();
      check(log_n - base == DEPTH, "R4 one handshake per entry", log_n - base, DEPTH);
      for (int i = 0; i < DEPTH; i++) begin
         check(log_we[base+i] && log_addr[base+i] == 8'h20 + i, "R4 drain order",
               log_addr[base+i], 8'h20 + i);
         check(mem_arr[8'h20 + i] == 32'h1100 + i, "R4 memory content",
               mem_arr[8'h20 + i], 32'h1100 + i);
      end
      check(mem_arr[8'h30] == 32'hA000_0030, "R3 rejected write absent",
            mem_arr[8'h30], 32'hA000_0030);
   endtask

   task automatic t_youngest();
      int w, lat; bit aa; logic [DW-1:0] d;
      mem_stall = 1;
      put_write(8'h50, 32'h0D01, w);
      put_write(8'h51, 32'h0D02, w);
      put_write(8'h50, 32'h0D03, w);
      do_read(8'h50, d, lat, aa);
      check(d == 32'h0D03, "R6 youngest match wins", d, 32'h0D03);
      do_read(8'h51, d, lat, aa);
      check(d == 32'h0D02, "R6 single match", d, 32'h0D02);
      mem_stall = 0;
      wait_idle();
      check(mem_arr[8'h50] == 32'h0D03, "R4 final value in order", mem_arr[8'h50], 32'h0D03);
   endtask

   task automatic t_miss_first();
      int w, base, lat; bit aa; logic [DW-1:0] d;
      mem_stall = 1;
      base = log_n;
      put_write(8'h60, 32'h6060, w);
      put_write(8'h61, 32'h6161, w);
      put_write(8'h62, 32'h6262, w);
      fork
         do_read(8'h70, d, lat, aa);
         begin
            repeat (6) @(negedge clk);
            mem_stall = 0;
         end
      join
      check(d == 32'hA000_0070, "R7 memory read data", d, 32'hA000_0070);
      check(aa, "R7 response after acknowledge", aa, 1);
      wait_idle();
      check(log_n - base == 4, "R8 transaction count", log_n - base, 4);
      check(log_we[base] && log_addr[base] == 8'h60, "R8 started write finishes", log_addr[base], 8'h60);
      check(!log_we[base+1] && log_addr[base+1] == 8'h70, "R8 read goes next",
            {log_we[base+1], log_addr[base+1]}, 9'h070);
      check(log_addr[base+2] == 8'h61 && log_addr[base+3] == 8'h62, "R4 queue resumes",
            log_addr[base+2], 8'h61);
   endtask

   task automatic t_evict_hold();
      int w, base, lat; bit aa; logic [DW-1:0] d;
      mem_stall = 1;
      base = log_n;
      put_evict(6'h09, 32'hE000);
      #1;
      check(!ev_ready, "R9 second block refused", ev_ready, 0);
      do_read(8'h26, d, lat, aa);
      check(d == 32'hE002 && lat == 0, "R9 read from held block", d, 32'hE002);
      put_write(8'h80, 32'h8080, w);
      mem_stall = 0;
      wait_idle();
      for (int k = 0; k < BLK; k++) begin
         check(log_we[base+k] && log_addr[base+k] == 8'h24 + k, "R10 held words ascending",
               log_addr[base+k], 8'h24 + k);
         check(mem_arr[8'h24 + k] == 32'hE000 + k, "R10 held block written",
               mem_arr[8'h24 + k], 32'hE000 + k);
      end
      check(log_addr[base+BLK] == 8'h80, "R10 later queue write after block",
            log_addr[base+BLK], 8'h80);
   endtask

   task automatic t_evict_after_read();
      int w, base, lat; bit aa; logic [DW-1:0] d;
      mem_stall = 1;
      put_write(8'h90, 32'h9090, w);
      #1;
      check(!ev_ready, "R9 refused while queue holds data", ev_ready, 0);
      mem_stall = 0;
      wait_idle();
      mem_stall = 1;
      base = log_n;
      fork
         do_read(8'h44, d, lat, aa);
         begin
            @(negedge clk); #1;
            while (rd_ready) begin @(negedge clk); #1; end
            put_evict(6'h0C, 32'hF000);
            repeat (3) @(negedge clk);
            mem_stall = 0;
         end
      join
      check(d == 32'hA000_0044, "R7 miss data with block held", d, 32'hA000_0044);
      wait_idle();
      check(!log_we[base] && log_addr[base] == 8'h44, "R10 read before write-back",
            log_addr[base], 8'h44);
      for (int k = 0; k < BLK; k++)
         check(log_we[base+1+k] && log_addr[base+1+k] == 8'h30 + k, "R10 write-back follows read",
               log_addr[base+1+k], 8'h30 + k);
   endtask

   task automatic t_req_stable();
      int w;
      logic [AW-1:0] a0; logic [DW-1:0] d0; bit same;
      mem_stall = 1;
      put_write(8'hB0, 32'hB0B0, w);
      put_write(8'hB1, 32'hB1B1, w);
      @(negedge clk); #1;
      a0 = mem_addr; d0 = mem_wdata; same = mem_req;
      repeat (5) begin
         @(negedge clk); #1;
         if (!mem_req || mem_addr != a0 || mem_wdata != d0 || !mem_we) same = 0;
      end
      check(same && a0 == 8'hB0, "R11 request held while stalled", a0, 8'hB0);
      mem_stall = 0;
      wait_idle();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      t_reset();
      t_fill_and_drain();
      t_youngest();
      t_miss_first();
      t_evict_hold();
      t_evict_after_read();
      t_req_stable();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %h expected %h", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule